// File: doc/BRIEF.md
# Aligned Product Multiply-Accumulate Unit

This block is a signed 16 x 16 multiply-accumulate datapath with two guarded accumulators. A coefficient operand and a data operand are multiplied into a registered 32-bit product. One cycle later, that product is repositioned by a two-bit alignment code and either loaded into, or added to, one of two 36-bit accumulators. Each accumulator carries four guard bits above the 32-bit data field.

The alignment modes let a caller pick where the binary point of the accumulated result sits. One example is a coefficient with 14 fraction bits multiplied by an integer sample. When that product is moved up two places, it yields a sum with 16 integer bits and 16 fraction bits below the guard bits.

Software-visible results are the low 32 bits of each accumulator. The guard bits, together with a sticky overflow flag per accumulator, are seen only in a separate status word. Saturation of an overflowing result is optional and is chosen per operation.

Top module: `mac_align_acc`

## Requirements
- R1: One clock edge after a cycle with `in_valid` high, `prod_out` equals the signed product of `coef_in` and `data_in` as a 32-bit two's complement value. `prod_out` holds its value in cycles where `in_valid` is low.
- R2: Alignment code 2'b00, and also code 2'b11, uses the product unshifted, with product bit 31 copied into accumulator bits 35..32.
- R3: Alignment code 2'b01 shifts the product right by two places arithmetically, so the result is the floor of the product divided by 4, sign-extended to 36 bits.
- R4: Alignment code 2'b10 places product bits 31..0 at accumulator bits 33..2. Bits 1..0 become zero, and product bit 31 fills bits 35..34.
- R5: `acc_op`=0 loads the aligned product and `acc_op`=1 adds it to the current value, wrapping at 36 bits. `dest_sel`=0 writes accumulator 0 and `dest_sel`=1 writes accumulator 1. The result appears two clock edges after the `in_valid` cycle, and the other accumulator is left unchanged.
- R6: A result whose bits 35..31 are not all equal counts as an overflow. When `sat_en` was set with the operation, an overflowing result is stored as 0x0_7FFF_FFFF if bit 35 is 0, and as 0xF_8000_0000 if bit 35 is 1.
- R7: When `sat_en` is clear, the full 36-bit result is stored even on overflow.
- R8: `status_word[8]` (accumulator 0) and `status_word[9]` (accumulator 1) are sticky overflow flags. A flag is set by an overflowing write to its accumulator. Both flags are cleared by `ovf_clr` at a clock edge, but a flag is still set if an overflow lands on the same edge.
- R9: `status_word[3:0]` shows accumulator 0 bits 35..32 and `status_word[7:4]` shows accumulator 1 bits 35..32. `acc0_data` and `acc1_data` show bits 31..0.
- R10: Synchronous active-high `rst` clears the product, both accumulators, the flags and the pipeline.
- R11: Without `in_valid`, neither accumulator changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| coef_in | input | 16 | Signed coefficient operand |
| data_in | input | 16 | Signed data operand |
| align_mode | input | 2 | Product alignment code |
| sat_en | input | 1 | Saturate the result on overflow |
| acc_op | input | 1 | 0 = load, 1 = accumulate |
| dest_sel | input | 1 | Target accumulator |
| ovf_clr | input | 1 | Clear both sticky overflow flags |
| prod_out | output | 32 | Registered product |
| acc0_data | output | 32 | Accumulator 0 bits 31..0 |
| acc1_data | output | 32 | Accumulator 1 bits 31..0 |
| status_word | output | 10 | Guard bits and sticky overflow flags |

## Verification
The bench sweeps extreme operand pairs, including -32768 squared and 32767 x -32768, through all four alignment codes. It watches three faults: sign extension that pads with zeros, a right shift that rounds toward zero on negative products, and a left shift that leaves stale low bits. Long accumulation runs carry a sum past the 32-bit range and through the 36-bit wrap. A design that saturates without being asked, picks the wrong clamp polarity, or detects overflow at the wrong bit would store a different value there. The bench also clears the flags on the same edge as an overflowing write, and leaves the inputs changing with no valid strobe. A design that lets the clear win, or that writes an accumulator without a valid operation, shows up in the status word or the data outputs.

// File: rtl/mac_align_pkg.sv
package mac_align_pkg;

    localparam int unsigned OPND_W_DEF  = 16;
    localparam int unsigned GUARD_W_DEF = 4;
    localparam int unsigned ALIGN_SHIFT = 2;

    typedef enum logic [1:0] {
        ALN_FLAT     = 2'b00,
        ALN_DOWN2    = 2'b01,
        ALN_UP2      = 2'b10,
        ALN_FLAT_ALT = 2'b11
    } aln_mode_e;

    typedef struct packed {
        aln_mode_e mode;
        logic      sat;
        logic      accum;
        logic      dest;
    } mac_ctrl_t;

endpackage

// File: rtl/mac_prod_stage.sv
module mac_prod_stage
    import mac_align_pkg::*;
#(
    parameter int unsigned OPND_W = OPND_W_DEF,
    localparam int unsigned PROD_W = 2 * OPND_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_in,
    input  logic [OPND_W-1:0] coef,
    input  logic [OPND_W-1:0] data,
    input  mac_ctrl_t         ctrl_in,
    output logic [PROD_W-1:0] prod_q,
    output logic              vld_q,
    output mac_ctrl_t         ctrl_q
);

    logic signed [PROD_W-1:0] prod_d;

    always_comb prod_d = $signed(coef) * $signed(data);

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
            vld_q  <= 1'b0;
            ctrl_q <= '0;
        end else begin
            vld_q <= vld_in;
            if (vld_in) begin
                prod_q <= prod_d;
                ctrl_q <= ctrl_in;
            end
        end
    end

endmodule

// File: rtl/mac_aligner.sv
module mac_aligner
    import mac_align_pkg::*;
#(
    parameter int unsigned PROD_W  = 2 * OPND_W_DEF,
    parameter int unsigned GUARD_W = GUARD_W_DEF,
    localparam int unsigned ACC_W  = PROD_W + GUARD_W
) (
    input  logic [PROD_W-1:0] prod,
    input  aln_mode_e         mode,
    output logic [ACC_W-1:0]  aligned
);

    logic [ACC_W-1:0] ext;

    always_comb begin
        ext = {{GUARD_W{prod[PROD_W-1]}}, prod};
        unique case (mode)
            ALN_DOWN2: aligned = {{ALIGN_SHIFT{ext[ACC_W-1]}}, ext[ACC_W-1:ALIGN_SHIFT]};
            ALN_UP2:   aligned = {ext[ACC_W-1-ALIGN_SHIFT:0], {ALIGN_SHIFT{1'b0}}};
            default:   aligned = ext;
        endcase
    end

endmodule

// File: rtl/mac_acc_lane.sv
module mac_acc_lane #(
    parameter int unsigned PROD_W  = 32,
    parameter int unsigned GUARD_W = 4,
    localparam int unsigned ACC_W  = PROD_W + GUARD_W,
    localparam int unsigned TOP_W  = GUARD_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             accum,
    input  logic             sat,
    input  logic             clr,
    input  logic [ACC_W-1:0] addend,
    output logic [ACC_W-1:0] acc_q,
    output logic             sticky_q
);

    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] clamp;
    logic [ACC_W-1:0] nxt;
    logic [TOP_W-1:0] top;
    logic             ovf;

    always_comb begin
        sum   = accum ? acc_q + addend : addend;
        top   = sum[ACC_W-1:PROD_W-1];
        ovf   = !((&top) || !(|top));
        clamp = sum[ACC_W-1] ? {{TOP_W{1'b1}}, {(PROD_W-1){1'b0}}}
                             : {{TOP_W{1'b0}}, {(PROD_W-1){1'b1}}};
        nxt   = (ovf && sat) ? clamp : sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            sticky_q <= 1'b0;
        end else begin
            if (wr_en) acc_q <= nxt;
            sticky_q <= (sticky_q && !clr) || (wr_en && ovf);
        end
    end

endmodule

// File: rtl/mac_align_acc.sv
module mac_align_acc
    import mac_align_pkg::*;
#(
    parameter int unsigned OPND_W  = OPND_W_DEF,
    parameter int unsigned GUARD_W = GUARD_W_DEF,
    localparam int unsigned PROD_W = 2 * OPND_W,
    localparam int unsigned ACC_W  = PROD_W + GUARD_W,
    localparam int unsigned STAT_W = 2 * GUARD_W + 2,
    localparam int unsigned N_ACC  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OPND_W-1:0] coef_in,
    input  logic [OPND_W-1:0] data_in,
    input  logic [1:0]        align_mode,
    input  logic              sat_en,
    input  logic              acc_op,
    input  logic              dest_sel,
    input  logic              ovf_clr,
    output logic [PROD_W-1:0] prod_out,
    output logic [PROD_W-1:0] acc0_data,
    output logic [PROD_W-1:0] acc1_data,
    output logic [STAT_W-1:0] status_word
);

    mac_ctrl_t        ctrl_in;
    mac_ctrl_t        pipe_ctrl;
    logic             pipe_vld;
    logic             pipe_dest;
    logic             pipe_sat;
    logic [ACC_W-1:0] aligned;
    logic [ACC_W-1:0] acc_q  [N_ACC];
    logic [N_ACC-1:0] sticky;

    always_comb begin
        ctrl_in.mode  = aln_mode_e'(align_mode);
        ctrl_in.sat   = sat_en;
        ctrl_in.accum = acc_op;
        ctrl_in.dest  = dest_sel;
    end

    mac_prod_stage #(.OPND_W(OPND_W)) u_prod (
        .clk    (clk),
        .rst    (rst),
        .vld_in (in_valid),
        .coef   (coef_in),
        .data   (data_in),
        .ctrl_in(ctrl_in),
        .prod_q (prod_out),
        .vld_q  (pipe_vld),
        .ctrl_q (pipe_ctrl)
    );

    assign pipe_dest = pipe_ctrl.dest;
    assign pipe_sat  = pipe_ctrl.sat;

    mac_aligner #(.PROD_W(PROD_W), .GUARD_W(GUARD_W)) u_align (
        .prod   (prod_out),
        .mode   (pipe_ctrl.mode),
        .aligned(aligned)
    );

    for (genvar g = 0; g < N_ACC; g++) begin : g_lane
        mac_acc_lane #(.PROD_W(PROD_W), .GUARD_W(GUARD_W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (pipe_vld && (pipe_ctrl.dest == 1'(g))),
            .accum   (pipe_ctrl.accum),
            .sat     (pipe_ctrl.sat),
            .clr     (ovf_clr),
            .addend  (aligned),
            .acc_q   (acc_q[g]),
            .sticky_q(sticky[g])
        );
    end

    assign acc0_data   = acc_q[0][PROD_W-1:0];
    assign acc1_data   = acc_q[1][PROD_W-1:0];
    assign status_word = {sticky[1], sticky[0],
                          acc_q[1][ACC_W-1:PROD_W], acc_q[0][ACC_W-1:PROD_W]};

endmodule

// File: rtl/mac_align_chk.sv
module mac_align_chk #(
    parameter int unsigned OPND_W  = 16,
    parameter int unsigned GUARD_W = 4,
    localparam int unsigned PROD_W = 2 * OPND_W,
    localparam int unsigned STAT_W = 2 * GUARD_W + 2
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [OPND_W-1:0] coef_in,
    input logic [OPND_W-1:0] data_in,
    input logic              ovf_clr,
    input logic [PROD_W-1:0] prod_out,
    input logic [PROD_W-1:0] acc0_data,
    input logic [PROD_W-1:0] acc1_data,
    input logic [STAT_W-1:0] status_word,
    input logic              st_valid,
    input logic              st_dest,
    input logic              st_sat
);

    logic signed [PROD_W-1:0] exp_p;
    always_comb exp_p = $signed(coef_in) * $signed(data_in);

    // R1: registered product
    p_product_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> prod_out == $past(exp_p));

    // R10: reset clears visible state
    p_reset_r10: assert property (@(posedge clk)
        rst |=> (prod_out == '0 && acc0_data == '0 && acc1_data == '0 && status_word == '0));

    // R11: no write without a valid pipeline stage
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !st_valid |=> ($stable(acc0_data) && $stable(acc1_data)
                       && $stable(status_word[2*GUARD_W-1:0])));

    // R5: the non-selected accumulator is untouched
    p_other_lane_r5: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_dest) |=> ($stable(acc1_data) && $stable(status_word[2*GUARD_W-1:GUARD_W])));

    // R6: a saturating write leaves a value that fits 32 signed bits
    p_sat_range_r6: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_sat && !st_dest) |=>
            ((status_word[GUARD_W-1:0] == '0 && !acc0_data[PROD_W-1]) ||
             (status_word[GUARD_W-1:0] == '1 && acc0_data[PROD_W-1])));

    // R8: flags stay set until cleared
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (status_word[2*GUARD_W] && !ovf_clr) |=> status_word[2*GUARD_W]);

endmodule

bind mac_align_acc mac_align_chk #(.OPND_W(OPND_W), .GUARD_W(GUARD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .coef_in    (coef_in),
    .data_in    (data_in),
    .ovf_clr    (ovf_clr),
    .prod_out   (prod_out),
    .acc0_data  (acc0_data),
    .acc1_data  (acc1_data),
    .status_word(status_word),
    .st_valid   (pipe_vld),
    .st_dest    (pipe_dest),
    .st_sat     (pipe_sat)
);

// File: tb/sim_mac_align_acc.sv
`timescale 1ns/1ps
module sim_mac_align_acc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] coef_in = '0;
    logic [15:0] data_in = '0;
    logic [1:0]  align_mode = '0;
    logic        sat_en = 1'b0;
    logic        acc_op = 1'b0;
    logic        dest_sel = 1'b0;
    logic        ovf_clr = 1'b0;
    logic [31:0] prod_out;
    logic [31:0] acc0_data;
    logic [31:0] acc1_data;
    logic [9:0]  status_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    longint model_acc [2];
    bit     model_stk [2];

    always #2 clk = ~clk;

    mac_align_acc u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .coef_in(coef_in),
        .data_in(data_in), .align_mode(align_mode), .sat_en(sat_en),
        .acc_op(acc_op), .dest_sel(dest_sel), .ovf_clr(ovf_clr),
        .prod_out(prod_out), .acc0_data(acc0_data), .acc1_data(acc1_data),
        .status_word(status_word)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic longint wrap36(input longint v);
        longint w;
        w = v & ((64'sd1 <<< 36) - 1);
        if (w >= (64'sd1 <<< 35)) w = w - (64'sd1 <<< 36);
        return w;
    endfunction

    task automatic check_state(input string tag0, input string tag1);
        logic [35:0] e0, e1;
        e0 = model_acc[0][35:0];
        e1 = model_acc[1][35:0];
        chk(acc0_data == e0[31:0], tag0, acc0_data, e0[31:0]);
        chk(acc1_data == e1[31:0], tag1, acc1_data, e1[31:0]);
        chk(status_word[3:0] == e0[35:32], "R9 guard0", status_word[3:0], e0[35:32]);
        chk(status_word[7:4] == e1[35:32], "R9 guard1", status_word[7:4], e1[35:32]);
        chk(status_word[8] == model_stk[0], "R8 sticky0", status_word[8], model_stk[0]);
        chk(status_word[9] == model_stk[1], "R8 sticky1", status_word[9], model_stk[1]);
    endtask

    task automatic op(input int c, input int d, input int m, input bit s,
                      input bit a, input bit dst, input bit clr);
        longint p, al, w;
        logic [31:0] pe;
        bit ov;
        string tg;
        @(negedge clk);
        coef_in = 16'(c); data_in = 16'(d); align_mode = 2'(m);
        sat_en = s; acc_op = a; dest_sel = dst; in_valid = 1'b1; ovf_clr = 1'b0;
        @(negedge clk);
        in_valid = 1'b0; ovf_clr = clr;
        p = longint'(c) * longint'(d);
        pe = p[31:0];
        chk(prod_out == pe, "R1 product", prod_out, pe);
        if (m == 2)      al = p * 4;
        else if (m == 1) al = (p < 0) ? (p - 3) / 4 : p / 4;
        else             al = p;
        w = wrap36(a ? model_acc[dst] + al : al);
        ov = (w > 64'sd2147483647) || (w < -64'sd2147483648);
        if (m == 1)      tg = "R3 shift down";
        else if (m == 2) tg = "R4 shift up";
        else             tg = "R2 flat";
        if (a) tg = "R5 accumulate";
        if (ov && s)  begin w = (w > 0) ? 64'sd2147483647 : -64'sd2147483648; tg = "R6 saturate"; end
        else if (ov)  tg = "R7 no saturate";
        if (clr) begin model_stk[0] = 0; model_stk[1] = 0; end
        if (ov) model_stk[dst] = 1;
        model_acc[dst] = w;
        @(negedge clk);
        ovf_clr = 1'b0;
        if (dst) check_state("R5 other lane", tg);
        else     check_state(tg, "R5 other lane");
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int vals [10] = '{-32768, -32767, -16384, -1, 0, 1, 2, 16383, 16384, 32767};
        logic [31:0] hold_p;
        model_acc[0] = 0; model_acc[1] = 0; model_stk[0] = 0; model_stk[1] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(prod_out == 0, "R10 reset product", prod_out, 0);
        check_state("R10 reset acc0", "R10 reset acc1");

        // alignment sweep with loads
        for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++)
                for (int m = 0; m < 4; m++)
                    op(vals[i], vals[j], m, ((i + j) % 2) == 1, 1'b0, (j % 2) == 1, 1'b0);

        // long accumulation through 36-bit wrap, no saturation
        op(0, 0, 0, 1'b0, 1'b0, 1'b1, 1'b1);
        for (int k = 0; k < 20; k++) op(32767, 32767, 2, 1'b0, 1'b1, 1'b1, 1'b0);

        // saturating negative accumulation on a0
        op(0, 0, 0, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 8; k++) op(-32768, 32767, 2, 1'b1, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) op(-7, 1234, k % 4, 1'b1, 1'b1, 1'b0, 1'b0);

        // flag clear without overflow, then clear racing an overflow
        op(3, 4, 0, 1'b0, 1'b0, 1'b0, 1'b1);
        op(32767, 32767, 2, 1'b0, 1'b0, 1'b1, 1'b1);

        // idle: operands move without a valid strobe
        @(negedge clk);
        hold_p = prod_out;
        for (int k = 0; k < 6; k++) begin
            coef_in = 16'(k * 4099); data_in = 16'(-k * 777);
            align_mode = 2'(k); acc_op = k[0]; dest_sel = k[1]; sat_en = k[0];
            @(negedge clk);
            chk(prod_out == hold_p, "R1 product hold", prod_out, hold_p);
            check_state("R11 idle acc0", "R11 idle acc1");
        end

        // mid-run reset
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_acc[0] = 0; model_acc[1] = 0; model_stk[0] = 0; model_stk[1] = 0;
        chk(prod_out == 0, "R10 reset product", prod_out, 0);
        check_state("R10 reset acc0", "R10 reset acc1");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule